// File: doc/BRIEF.md
# Converter Wake and Conversion Sequencer

This block drives the single start strobe of an external sampling converter that stays powered down between samples. The strobe's rising edge wakes the converter. Its falling edge marks the start of the conversion. The block holds the strobe high for the wake-up time that the selected reference needs. It then lowers the strobe and waits out the worst-case conversion time. After that it raises a one-cycle done pulse, and the data bus can be read.

The external reference wakes quickly. The on-chip reference needs far longer. The reference choice is taken from an input at the moment a request is accepted. The strobe always falls exactly when wake-up completes. This meets the rule that the strobe must not fall early with the on-chip reference. It also keeps the strobe high no longer than the wake-up time, so the converter spends the least time awake. An optional pacing counter spaces successive wake-ups by a fixed sample period. All durations are parameters given in clock cycles.

Top module: `adc_wake_seq`

## Requirements
- R1: A synchronous active-high reset drives strobe, busy and done low at the next clock edge. It abandons any sequence in progress and clears the pacing window, so a request made just after reset is accepted.
- R2: When the block is idle and pacing allows, `req_i` high at a clock edge is accepted. Strobe and busy are both high from that edge.
- R3: With `ref_sel_i` = 0 (external reference) at acceptance, the strobe stays high for exactly `WAKE_EXT_CYC` cycles.
- R4: With `ref_sel_i` = 1 (on-chip reference) at acceptance, the strobe stays high for exactly `WAKE_INT_CYC` cycles.
- R5: `ref_sel_i` is sampled only at the acceptance edge. Changing it during a sequence does not alter that sequence's strobe width.
- R6: `done_o` is high for exactly one cycle. It rises `CONV_CYC` cycles after the strobe falls, at the same edge where busy falls.
- R7: Busy is high from the cycle the strobe rises until the done pulse. A request made while busy is ignored and is not remembered.
- R8: With `PERIOD_CYC` > 1, successive strobe rising edges are at least `PERIOD_CYC` cycles apart. A request held high starts exactly `PERIOD_CYC` cycles after the previous rise. `PERIOD_CYC` ≤ 1 disables pacing.
- R9: A request pulse made while idle but before the pacing period has elapsed is dropped. No sequence follows from it.
- R10: The strobe is never high while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Sample request, sampled at each clock edge |
| ref_sel_i | input | 1 | Reference choice: 0 external, 1 on-chip |
| strobe_o | output | 1 | Converter start strobe (rise wakes, fall converts) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when conversion result is valid |

## Verification
The hardest case to reach is telling the pacing window apart from the busy interval. Both reject a request, but only the pacing window lets a held request start at an exact later cycle. The stimulus holds the request high across a whole sequence and measures the rise-to-rise distance. It separately sends lone pulses during the busy interval and during the idle part of the pacing window, then watches past the window's end to prove that neither was remembered. A flip of the reference input in the middle of a sequence, and a reset issued during wake-up, cover the sampling and abort paths.

// File: rtl/adc_wake_seq_pkg.sv
package adc_wake_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAKE = 2'd1,
    ST_CONV = 2'd2
  } seq_state_e;
endpackage

// File: rtl/seq_downcnt.sv
// Loadable down-counter that stops at zero.
module seq_downcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/seq_pacer.sv
// Throughput pacing: ready goes high PERIOD cycles after a start.
module seq_pacer #(
  parameter int PERIOD = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic ready
);
  generate
    if (PERIOD <= 1) begin : g_off
      logic unused_pace;
      assign unused_pace = ^{clk, rst, start};
      assign ready = 1'b1;
    end else begin : g_on
      localparam int PW = $clog2(PERIOD);
      localparam logic [PW-1:0] RELOAD = PW'(PERIOD - 1);
      seq_downcnt #(.W(PW)) u_win (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .load_val (RELOAD),
        .zero     (ready)
      );
    end
  endgenerate
endmodule

// File: rtl/adc_wake_seq.sv
module adc_wake_seq
  import adc_wake_seq_pkg::*;
#(
  parameter int WAKE_EXT_CYC = 100,
  parameter int WAKE_INT_CYC = 2500,
  parameter int CONV_CYC     = 42,
  parameter int PERIOD_CYC   = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic ref_sel_i,
  output logic strobe_o,
  output logic busy_o,
  output logic done_o
);
  localparam int MAX_WAKE = (WAKE_INT_CYC > WAKE_EXT_CYC) ? WAKE_INT_CYC : WAKE_EXT_CYC;
  localparam int MAX_PH   = (MAX_WAKE > CONV_CYC) ? MAX_WAKE : CONV_CYC;
  localparam int CNT_W    = $clog2(MAX_PH + 1);
  localparam logic [CNT_W-1:0] EXT_LD  = CNT_W'(WAKE_EXT_CYC - 1);
  localparam logic [CNT_W-1:0] INT_LD  = CNT_W'(WAKE_INT_CYC - 1);
  localparam logic [CNT_W-1:0] CONV_LD = CNT_W'(CONV_CYC - 1);

  seq_state_e       state;
  logic             accept;
  logic             pace_ready;
  logic             ph_load;
  logic             ph_zero;
  logic [CNT_W-1:0] ph_val;

  // A request is taken only when idle and the pacing window is open;
  // the reference choice matters only at this instant.
  assign accept  = (state == ST_IDLE) && req_i && pace_ready;
  assign ph_load = accept || ((state == ST_WAKE) && ph_zero);
  assign ph_val  = accept ? (ref_sel_i ? INT_LD : EXT_LD) : CONV_LD;

  seq_downcnt #(.W(CNT_W)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .load     (ph_load),
    .load_val (ph_val),
    .zero     (ph_zero)
  );

  seq_pacer #(.PERIOD(PERIOD_CYC)) u_pace (
    .clk   (clk),
    .rst   (rst),
    .start (accept),
    .ready (pace_ready)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      strobe_o <= 1'b0;
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state    <= ST_WAKE;
            strobe_o <= 1'b1;
            busy_o   <= 1'b1;
          end
        end
        ST_WAKE: begin
          if (ph_zero) begin
            state    <= ST_CONV;
            strobe_o <= 1'b0;
          end
        end
        ST_CONV: begin
          if (ph_zero) begin
            state  <= ST_IDLE;
            busy_o <= 1'b0;
            done_o <= 1'b1;
          end
        end
        default: begin
          state    <= ST_IDLE;
          strobe_o <= 1'b0;
          busy_o   <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/adc_wake_seq_chk.sv
module adc_wake_seq_chk #(
  parameter int WAKE_EXT_CYC = 100,
  parameter int WAKE_INT_CYC = 2500,
  parameter int CONV_CYC     = 42,
  parameter int PERIOD_CYC   = 1000
) (
  input logic clk,
  input logic rst,
  input logic ref_sel_i,
  input logic strobe_o,
  input logic busy_o,
  input logic done_o
);
  localparam int MAX_WAKE = (WAKE_INT_CYC > WAKE_EXT_CYC) ? WAKE_INT_CYC : WAKE_EXT_CYC;
  localparam int HW = $clog2(MAX_WAKE + 2);
  localparam int LW = $clog2(CONV_CYC + 2);
  localparam int GW = $clog2(PERIOD_CYC + 2);

  logic          strobe_q, ref_d, ref_lat;
  logic [HW-1:0] hi_cnt;
  logic [LW-1:0] lo_cnt;
  logic [GW-1:0] gap;
  logic          rise, fall;

  assign rise = strobe_o && !strobe_q;
  assign fall = !strobe_o && strobe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      ref_d    <= 1'b0;
      ref_lat  <= 1'b0;
      hi_cnt   <= '0;
      lo_cnt   <= '0;
      gap      <= GW'(PERIOD_CYC);
    end else begin
      strobe_q <= strobe_o;
      ref_d    <= ref_sel_i;
      if (rise) ref_lat <= ref_d;
      if (!strobe_o) hi_cnt <= '0;
      else if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
      if (!(busy_o && !strobe_o)) lo_cnt <= '0;
      else if (lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
      if (rise) gap <= GW'(1);
      else if (int'(gap) < PERIOD_CYC) gap <= gap + 1'b1;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R6
  AST_DONE_AFTER_CONV: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (int'(lo_cnt) == CONV_CYC)); // R6
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o))); // R7
  AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    strobe_o |-> busy_o); // R10
  AST_RISE_STARTS_BUSY: assert property (@(posedge clk) disable iff (rst)
    rise |-> $rose(busy_o)); // R2
  AST_NO_REWAKE: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !strobe_o) |=> !strobe_o); // R7
  AST_WAKE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    fall |-> (int'(hi_cnt) == (ref_lat ? WAKE_INT_CYC : WAKE_EXT_CYC))); // R3 R4 R5
  AST_PACE_GAP: assert property (@(posedge clk) disable iff (rst)
    rise |-> (int'(gap) >= PERIOD_CYC)); // R8
endmodule

bind adc_wake_seq adc_wake_seq_chk #(
  .WAKE_EXT_CYC (WAKE_EXT_CYC),
  .WAKE_INT_CYC (WAKE_INT_CYC),
  .CONV_CYC     (CONV_CYC),
  .PERIOD_CYC   (PERIOD_CYC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ref_sel_i (ref_sel_i),
  .strobe_o  (strobe_o),
  .busy_o    (busy_o),
  .done_o    (done_o)
);

// File: tb/adc_wake_seq_bench.sv
module adc_wake_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WE = 4;
  localparam int WI = 10;
  localparam int CV = 3;
  localparam int PD = 30;
  // bit 1: reference choice, bit 0: flip reference during the sequence
  localparam logic [1:0] VEC [4] = '{2'b00, 2'b10, 2'b01, 2'b11};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic ref_sel = 1'b0;
  logic strobe, busy, done;
  int   total = 0;
  int   fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_wake_seq #(
    .WAKE_EXT_CYC (WE),
    .WAKE_INT_CYC (WI),
    .CONV_CYC     (CV),
    .PERIOD_CYC   (PD)
  ) u_adc_wake_seq (
    .clk       (clk),
    .rst       (rst),
    .req_i     (req),
    .ref_sel_i (ref_sel),
    .strobe_o  (strobe),
    .busy_o    (busy),
    .done_o    (done)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  // One request pulse, optional reference flip; returns measured widths.
  task automatic run_seq(input logic r, input logic flip,
                         output int w, output int c);
    @(negedge clk); ref_sel = r; req = 1'b1;
    @(negedge clk); req = 1'b0;
    check("R2 strobe up after accept", int'(strobe), 1);
    check("R2 busy up after accept", int'(busy), 1);
    if (flip) ref_sel = !r;
    w = 0;
    while (strobe && w < 200) begin w++; @(negedge clk); end
    c = 0;
    while (busy && c < 200) begin c++; @(negedge clk); end
    check("R6 done with busy fall", int'(done), 1);
    @(negedge clk);
    check("R6 done one cycle", int'(done), 0);
  endtask

  task automatic count_rises(input int n, output int rises);
    logic prev;
    prev = strobe;
    rises = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (strobe && !prev) rises++;
      prev = strobe;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    summary();
  end

  initial begin
    int w, c, n, k;
    logic prev;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 strobe low after reset", int'(strobe), 0);
    check("R1 busy low after reset", int'(busy), 0);
    check("R1 done low after reset", int'(done), 0);

    // Vector table: R3, R4, R5, R6
    for (int i = 0; i < 4; i++) begin
      run_seq(VEC[i][1], VEC[i][0], w, c);
      if (VEC[i][1]) check("R4 on-chip wake width", w, WI);
      else           check("R3 external wake width", w, WE);
      if (VEC[i][0]) check("R5 flip ignored, width", w, VEC[i][1] ? WI : WE);
      check("R6 conversion wait", c, CV);
      repeat (PD + 2) @(negedge clk);
    end

    // R7: request during busy is ignored and not remembered
    @(negedge clk); ref_sel = 1'b0; req = 1'b1;
    @(negedge clk); req = 1'b0;
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
    check("R7 busy during wake", int'(busy), 1);
    count_rises(PD + 15, n);
    check("R7 busy request dropped", n, 0);
    check("R10 strobe low when idle", int'(strobe), 0);

    // R8: held request restarts exactly one period later
    @(negedge clk); req = 1'b1;
    @(negedge clk);
    check("R8 first start", int'(strobe), 1);
    prev = strobe; k = 0;
    while (k < 200) begin
      @(negedge clk); k++;
      if (strobe && !prev) break;
      prev = strobe;
    end
    req = 1'b0;
    check("R8 rise-to-rise distance", k, PD);
    repeat (PD + 5) @(negedge clk);

    // R9: idle pulse inside the pacing window is dropped
    run_seq(1'b0, 1'b0, w, c);
    repeat (5) @(negedge clk);
    req = 1'b1;
    @(negedge clk); req = 1'b0;
    check("R9 no start inside window", int'(strobe), 0);
    count_rises(PD + 5, n);
    check("R9 window pulse dropped", n, 0);

    // R1: reset during wake aborts and clears pacing
    @(negedge clk); ref_sel = 1'b1; req = 1'b1;
    @(negedge clk); req = 1'b0;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 strobe cleared mid-wake", int'(strobe), 0);
    check("R1 busy cleared mid-wake", int'(busy), 0);
    run_seq(1'b0, 1'b0, w, c);
    check("R1 accepted right after reset, width", w, WE);
    summary();
  end
endmodule